// File: doc/BRIEF.md
# Pulse Accumulator with Flags

This block counts pulses on one external input, into a 16-bit counter. It has two modes. In event mode every selected edge of the input adds one to the counter. In gated mode the counter adds one on each cycle of an external prescaled clock enable, as long as the input sits at its active level. Before any edge or level detection, the input passes through a two-flop synchronizer.

Two sticky flags record events:

- The overflow flag is set when the counter wraps.
- The input flag is set by the selected edge in event mode, and by the trailing edge of the gate in gated mode.

Each flag has its own interrupt enable, and the two masked flags are combined into one interrupt request. Software reaches the control bits, the flags and the counter through a simple byte-wide register bus. The flags are cleared by writing ones to them. An optional fast-clear mode clears both flags whenever software reads or writes the counter.

Top module: `pulse_accum`

## Requirements
- R1: After reset, the control register, the flag register and the counter read 0 and the interrupt request is low.
- R2: The register addresses are as follows. Address 0 is control: bit0 enable, bit1 gated mode, bit2 invert, bit3 fast clear, bit4 overflow interrupt enable, bit5 input interrupt enable. Address 1 holds the flags: bit1 overflow, bit0 input. Address 2 is the counter high byte and address 3 the counter low byte. Reserved bits read as 0.
- R3: In event mode (bit1=0) the counter adds one, and the input flag is set, on each rising edge of the synchronized input when invert=0, and on each falling edge when invert=1.
- R4: In gated mode (bit1=1) the counter adds one on each cycle with the prescale enable high while the input is at its active level (high when invert=0, low when invert=1). Otherwise it holds.
- R5: In gated mode the input flag is set by the trailing edge of the active level, never by the leading edge.
- R6: A count that wraps from 0xFFFF to 0x0000 sets the overflow flag.
- R7: Writing a 1 to a flag bit clears that flag. Writing a 0 leaves it unchanged.
- R8: When a hardware set and a write-one-clear hit the same flag in the same cycle, the flag ends up set.
- R9: With fast clear enabled, any read or write of address 2 or 3 clears both flags. Reads of addresses 0 and 1 do not clear them.
- R10: The interrupt request is high exactly when a set flag has its interrupt enable set.
- R11: A bus write to the counter in the same cycle as an increment leaves the written value, and the increment is lost.
- R12: With enable=0, input activity changes neither the counter nor the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 1 | Asynchronous pulse or gate input |
| presc_en | input | 1 | Prescaled clock enable for gated mode |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| irq | output | 1 | Combined interrupt request |

## Verification
The embedded assertions watch several rules on every cycle:

- the wrap-to-overflow rule;
- the hold of the counter when it is neither incremented nor written;
- write-one-clear;
- the survival of a flag that is set and cleared in the same cycle;
- the fast-clear effect;
- the reserved bits reading as zero.

Other behaviour can only be shown by the bench's scenarios. These scenarios cover:

- edge polarity through the synchronizer latency;
- gated counting against a known number of prescale pulses;
- a leading gate edge that leaves the flag alone while the trailing edge sets it;
- interrupt masking;
- a counter write that beats a coincident increment.

// File: rtl/pulse_accum.sv
module pulse_accum #(
  parameter int CNT_W   = 16,
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 2,
  parameter int SYNC_N  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_in,
  input  logic              presc_en,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int CTL_W = 6;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [SYNC_N-1:0] sync_q;
  logic              pin_d;
  logic [CTL_W-1:0]  ctl_q;
  logic [1:0]        flg_q;
  logic [CNT_W-1:0]  cnt_q;

  logic pin_s, rise, fall, sel_edge, trail, gate_on;
  logic inc, set_inf, set_ovf, cnt_wr_hi, cnt_wr_lo, cnt_wr, cnt_acc;
  logic [1:0] clr, set;

  wire en    = ctl_q[0];
  wire gated = ctl_q[1];
  wire inv   = ctl_q[2];
  wire fclr  = ctl_q[3];
  wire ovie  = ctl_q[4];
  wire inie  = ctl_q[5];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync_q <= '0;
      pin_d  <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_N-2:0], pin_in};
      pin_d  <= sync_q[SYNC_N-1];
    end

  assign pin_s    = sync_q[SYNC_N-1];
  assign rise     = pin_s & ~pin_d;
  assign fall     = ~pin_s & pin_d;
  assign sel_edge = inv ? fall : rise;
  assign trail    = inv ? rise : fall;
  assign gate_on  = pin_s ^ inv;

  assign inc     = en & (gated ? (gate_on & presc_en) : sel_edge);
  assign set_inf = en & (gated ? trail : sel_edge);

  wire wr_any = bus_sel & bus_wr;
  wire wr_ctl = wr_any & (bus_addr == 2'd0);
  wire wr_flg = wr_any & (bus_addr == 2'd1);
  assign cnt_wr_hi = wr_any & (bus_addr == 2'd2);
  assign cnt_wr_lo = wr_any & (bus_addr == 2'd3);
  assign cnt_wr    = cnt_wr_hi | cnt_wr_lo;
  assign cnt_acc   = bus_sel & bus_addr[1] & fclr;

  assign set_ovf = inc & ~cnt_wr & (cnt_q == CNT_MAX);
  assign set     = {set_ovf, set_inf};
  assign clr     = cnt_acc ? 2'b11 : (wr_flg ? bus_wdata[1:0] : 2'b00);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      ctl_q <= '0;
    else if (wr_ctl) ctl_q <= bus_wdata[CTL_W-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) flg_q <= '0;
    else        flg_q <= (flg_q & ~clr) | set;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         cnt_q <= '0;
    else if (cnt_wr_hi) cnt_q[CNT_W-1:DATA_W] <= bus_wdata;
    else if (cnt_wr_lo) cnt_q[DATA_W-1:0]     <= bus_wdata;
    else if (inc)       cnt_q <= cnt_q + 1'b1;

  always_comb
    case (bus_addr)
      2'd0:    bus_rdata = {{(DATA_W-CTL_W){1'b0}}, ctl_q};
      2'd1:    bus_rdata = {{(DATA_W-2){1'b0}}, flg_q};
      2'd2:    bus_rdata = cnt_q[CNT_W-1:DATA_W];
      default: bus_rdata = cnt_q[DATA_W-1:0];
    endcase

  assign irq = (flg_q[1] & ovie) | (flg_q[0] & inie);

  AST_OVF_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !cnt_wr && cnt_q == CNT_MAX) |=> (flg_q[1] && cnt_q == '0)); // R6

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !cnt_wr) |=> $stable(cnt_q)); // R4

  AST_W1C_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_flg && bus_wdata[1] && !set_ovf) |=> !flg_q[1]); // R7

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_flg && bus_wdata[0] && set_inf) |=> flg_q[0]); // R8

  AST_FAST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_addr[1] && fclr && !set_ovf && !set_inf) |=> (flg_q == 2'b00)); // R9

  AST_IDLE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !cnt_wr) |=> $stable(cnt_q)); // R12

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd1) |-> (bus_rdata[DATA_W-1:2] == '0)); // R2
endmodule

// File: tb/pulse_accum_bench.sv
module pulse_accum_bench;
  logic clk = 0, rst_n = 0, pin_in = 0, presc_en = 0;
  logic bus_sel = 0, bus_wr = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic irq;
  int checks = 0, errors = 0;
  logic mon_req = 0;
  int    exp_q[$];
  bit    kind_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  pulse_accum u_pulse_accum (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .presc_en(presc_en),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, input int exp, input string tag);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    exp_q.push_back(exp); kind_q.push_back(1'b0); tag_q.push_back(tag);
    mon_req = 1;
    @(negedge clk);
    bus_sel = 0; mon_req = 0;
  endtask

  task automatic chk_irq(input bit exp, input string tag);
    @(negedge clk);
    exp_q.push_back(int'(exp)); kind_q.push_back(1'b1); tag_q.push_back(tag);
    mon_req = 1;
    @(negedge clk);
    mon_req = 0;
  endtask

  task automatic pulse();
    @(negedge clk); pin_in = 1;
    repeat (4) @(negedge clk);
    pin_in = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic presc(input int n);
    @(negedge clk); presc_en = 1;
    repeat (n - 1) @(negedge clk);
    @(negedge clk); presc_en = 0;
    repeat (2) @(negedge clk);
  endtask

  always @(negedge clk) begin
    #1;
    if (mon_req && exp_q.size() > 0) begin
      int e; bit k; string t; int act;
      e = exp_q.pop_front(); k = kind_q.pop_front(); t = tag_q.pop_front();
      act = k ? int'(irq) : int'(bus_rdata);
      checks++;
      if (act != e) begin
        errors++;
        $display("FAIL %s: actual=0x%0h expected=0x%0h", t, act, e);
      end
    end
  end

  task automatic finish_run();
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard: actual=%0d expected=0 pending items", exp_q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(0, 0, "R1 ctl"); rd(1, 0, "R1 flags"); rd(2, 0, "R1 cnt hi"); rd(3, 0, "R1 cnt lo");
    chk_irq(0, "R1 irq");
    // R3 event mode rising
    wr(0, 8'h01);
    rd(0, 8'h01, "R2 ctl readback");
    repeat (3) pulse();
    rd(3, 3, "R3 rising count"); rd(1, 8'h01, "R3 input flag");
    // R3 falling edge select
    wr(0, 8'h05);
    repeat (2) pulse();
    rd(3, 5, "R3 falling count");
    // R7 write zero no effect, write one clears
    wr(1, 8'h00); rd(1, 8'h01, "R7 write zero");
    wr(1, 8'h01); rd(1, 8'h00, "R7 write one");
    // R4/R5 gated, active high
    wr(0, 8'h03); wr(2, 0); wr(3, 0);
    @(negedge clk); pin_in = 1;
    repeat (4) @(negedge clk);
    rd(1, 8'h00, "R5 leading edge no flag");
    presc(5);
    rd(3, 5, "R4 gated active-high count");
    @(negedge clk); pin_in = 0;
    repeat (4) @(negedge clk);
    presc(3);
    rd(3, 5, "R4 gate inactive hold");
    rd(1, 8'h01, "R5 trailing edge flag");
    // R4/R5 gated, active low
    wr(1, 8'h01); wr(0, 8'h07);
    presc(3);
    rd(3, 8, "R4 gated active-low count");
    @(negedge clk); pin_in = 1;
    repeat (4) @(negedge clk);
    rd(1, 8'h01, "R5 active-low trailing flag");
    @(negedge clk); pin_in = 0;
    repeat (4) @(negedge clk);
    // R6 overflow
    wr(1, 8'h03); wr(0, 8'h01); wr(2, 8'hFF); wr(3, 8'hFE);
    rd(2, 8'hFF, "R2 cnt hi write");
    repeat (2) pulse();
    rd(2, 0, "R6 wrap hi"); rd(3, 0, "R6 wrap lo");
    rd(1, 8'h03, "R6 overflow flag");
    // R10 interrupt masking
    chk_irq(0, "R10 masked");
    wr(0, 8'h11); chk_irq(1, "R10 ovf enabled");
    wr(1, 8'h02); rd(1, 8'h01, "R7 clear ovf only"); chk_irq(0, "R10 ovf cleared");
    wr(0, 8'h21); chk_irq(1, "R10 input enabled");
    wr(0, 8'h01); chk_irq(0, "R10 input masked");
    // R9 fast clear
    wr(0, 8'h09);
    rd(1, 8'h01, "R9 flag read keeps");
    rd(3, 0, "R9 counter read");
    rd(1, 8'h00, "R9 cleared by read");
    pulse();
    rd(1, 8'h01, "R9 flag set again");
    wr(3, 8'h40);
    rd(1, 8'h00, "R9 cleared by write");
    // R8 set wins over clear
    wr(0, 8'h01);
    @(negedge clk); pin_in = 1;
    @(negedge clk);
    wr(1, 8'h01);
    rd(1, 8'h01, "R8 set beats clear");
    rd(3, 8'h41, "R8 count");
    @(negedge clk); pin_in = 0;
    repeat (4) @(negedge clk);
    // R11 write beats increment
    @(negedge clk); pin_in = 1;
    @(negedge clk);
    wr(3, 8'h10);
    rd(3, 8'h10, "R11 write priority");
    @(negedge clk); pin_in = 0;
    repeat (4) @(negedge clk);
    // R12 disabled
    wr(1, 8'h03); wr(0, 8'h00);
    pulse();
    rd(3, 8'h10, "R12 no count"); rd(1, 8'h00, "R12 no flag");
    wr(0, 8'h02); presc(4);
    rd(3, 8'h10, "R12 gated disabled");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule